// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit sits in a binary BCH read-path decoder, between the stage that divides a received sector by the minimal polynomials and the stage that solves for the error locator. For each odd syndrome index it receives one m-bit remainder word. It expands these words into the complete list of 2t syndromes over GF(2^m). The field is GF(2^13) for 512-byte sectors and GF(2^14) for 1024-byte sectors.

Software or an upstream sequencer loads the remainder words through a small write port. It then pulses `start` with the correction strength t and the field selection. The unit computes one syndrome index at a time, in increasing index order. To build an odd syndrome it walks the bits of the remainder word, accumulating field powers. To build an even syndrome it squares the syndrome at half the index. When the last syndrome is stored, a one-cycle `done` pulse marks completion, and every slot can then be read through a combinational read port.

Top module: `bch_syn_expand`

## Requirements
- R1: After synchronous reset, `done` is low and every syndrome slot reads zero.
- R2: With `cfg_wide` = 0 the arithmetic is GF(2^13) modulo x^13+x^4+x^3+x+1. With `cfg_wide` = 1 it is GF(2^14) modulo x^14+x^10+x^6+x+1. Elements are in polynomial basis, with bit k holding the coefficient of x^k, and alpha = x (value 2).
- R3: The word written at `ps_addr` = k (0 to 23) feeds syndrome 2k+1. S(2k+1) is the XOR of alpha^(((2k+1)·j) mod n) over every set bit j < m of that word, where n = 2^m − 1.
- R4: For even i from 2 to 2t, S(i) equals S(i/2) squared, which is alpha^((2·log S(i/2)) mod n). When S(i/2) is zero, S(i) is zero.
- R5: An accepted start clears slots 1 to 49. After the run, every slot above 2t reads zero, including slots written by an earlier run with a larger t.
- R6: If `start` is accepted at clock edge E, `done` is high for exactly one cycle, beginning at edge E + t·(m+1). It is low at all other times.
- R7: A `start` pulse, together with any change on `cfg_t` or `cfg_wide`, has no effect while a run is in progress. The run keeps its original timing and results.
- R8: `rd_data` shows slot `rd_addr` (0 to 49) combinationally. Slot 0 always reads zero. Results hold until the next accepted start.
- R9: With `cfg_wide` = 0, bit 13 of each partial word is ignored.
- R10: `cfg_t` may be any value from 1 to 24 and is latched when start is accepted. A run fills exactly slots 1 to 2t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| cfg_t | input | 5 | Correction capability t, 1 to 24 |
| cfg_wide | input | 1 | 0: GF(2^13), 1: GF(2^14) |
| ps_we | input | 1 | Partial-syndrome write enable |
| ps_addr | input | 5 | Partial-syndrome index k (odd syndrome 2k+1) |
| ps_data | input | 14 | Partial-syndrome remainder word |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | 6 | Syndrome slot to read |
| rd_data | output | 14 | Syndrome value of the selected slot |

## Verification
The power register, step register or bit counter could go wrong. A wrong power or step register corrupts the first odd syndrome that uses it and every later one. It also corrupts the even syndromes derived from those, so a single readout after `done` exposes it. A wrong bit counter or index counter moves the `done` pulse away from edge t·(m+1). The bench compares `done` against its own timing model on every clock, so such a fault is reported in the cycle where it happens. A missed clear shows up as stale nonzero slots above 2t, once a short run follows a long one.

// File: rtl/bch_syn_pkg.sv
`timescale 1ns/1ps
package bch_syn_pkg;
    localparam int MW    = 14;                 // widest field degree
    localparam int TMAX  = 24;                 // largest correction capability
    localparam int NSLOT = 2 * (TMAX + 1);     // syndrome slots, index 0..NSLOT-1
    localparam int IW    = $clog2(NSLOT);      // slot index width
    localparam int TW    = $clog2(TMAX + 1);   // t width
    localparam int KW    = $clog2(TMAX);       // partial word index width
    localparam int BW    = $clog2(MW);         // bit counter width

    typedef logic [MW-1:0] gf_t;

    localparam gf_t RED_NARROW = 14'h001B;     // low terms of x^13+x^4+x^3+x+1
    localparam gf_t RED_WIDE   = 14'h0443;     // low terms of x^14+x^10+x^6+x+1
    localparam gf_t GF_ONE     = 14'h0001;
    localparam gf_t GF_ALPHA   = 14'h0002;
    localparam gf_t GF_ALPHA2  = 14'h0004;

    typedef enum logic [1:0] {ST_IDLE, ST_ODD, ST_EVEN} run_st_e;

    // multiply by alpha in the selected field
    function automatic gf_t gf_xtime(gf_t v, logic wide);
        gf_t r;
        r = v << 1;
        if (wide) begin
            if (v[MW-1]) r = r ^ RED_WIDE;
        end else begin
            r[MW-1] = 1'b0;
            if (v[MW-2]) r = r ^ RED_NARROW;
        end
        return r;
    endfunction

    // shift-and-add field multiply, MSB of b first
    function automatic gf_t gf_mul(gf_t a, gf_t b, logic wide);
        gf_t r;
        r = '0;
        for (int k = MW - 1; k >= 0; k--) begin
            r = gf_xtime(r, wide);
            if (b[k]) r = r ^ a;
        end
        return r;
    endfunction
endpackage

// File: rtl/bch_gf_mul.sv
`timescale 1ns/1ps
module bch_gf_mul
    import bch_syn_pkg::*;
(
    input  logic [MW-1:0] op_a,
    input  logic [MW-1:0] op_b,
    input  logic          wide,
    output logic [MW-1:0] prod
);
    always_comb prod = gf_mul(op_a, op_b, wide);
endmodule

// File: rtl/bch_ps_file.sv
`timescale 1ns/1ps
module bch_ps_file
    import bch_syn_pkg::*;
#(
    parameter int DEPTH = TMAX,
    parameter int AW    = KW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [MW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [MW-1:0] rdata
);
    logic [DEPTH-1:0][MW-1:0] words;

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (we && (int'(waddr) < DEPTH)) begin
            words[waddr] <= wdata;
        end
    end

    always_comb rdata = (int'(raddr) < DEPTH) ? words[raddr] : '0;

    AST_PS_STORED: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(waddr) < DEPTH)) |=> (words[$past(waddr)] == $past(wdata))); // R3
endmodule

// File: rtl/bch_syn_file.sv
`timescale 1ns/1ps
module bch_syn_file
    import bch_syn_pkg::*;
#(
    parameter int DEPTH = NSLOT,
    parameter int AW    = IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [MW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [MW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [MW-1:0] rdata_b
);
    logic [DEPTH-1:0][MW-1:0] slots;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slots <= '0;
        end else if (we && (waddr != '0) && (int'(waddr) < DEPTH)) begin
            slots[waddr] <= wdata;
        end
    end

    always_comb rdata_a = (int'(raddr_a) < DEPTH) ? slots[raddr_a] : '0;
    always_comb rdata_b = (int'(raddr_b) < DEPTH) ? slots[raddr_b] : '0;

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr |=> (slots == '0)); // R5
    AST_SLOT0_ZERO: assert property (@(posedge clk) disable iff (rst)
        we |=> (slots[0] == '0)); // R8
endmodule

// File: rtl/bch_syn_expand.sv
`timescale 1ns/1ps
module bch_syn_expand
    import bch_syn_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] cfg_t,
    input  logic          cfg_wide,
    input  logic          ps_we,
    input  logic [KW-1:0] ps_addr,
    input  logic [MW-1:0] ps_data,
    output logic          done,
    input  logic [IW-1:0] rd_addr,
    output logic [MW-1:0] rd_data
);
    run_st_e       state;
    logic [IW-1:0] idx;
    logic [BW-1:0] bitn;
    logic [TW-1:0] t_q;
    logic          wide_q;
    gf_t           step_q, run_q, acc_q;
    logic          done_q;

    logic          go;
    logic [TW-1:0] t_in;
    logic [IW-1:0] two_t;
    logic          last_bit, last_idx;
    logic [KW-1:0] ps_rsel;
    gf_t           ps_word, half_val, mul_a, mul_b, mul_y, acc_nxt;
    logic          syn_we;
    gf_t           syn_wdata;

    assign go       = (state == ST_IDLE) && start;
    assign t_in     = (cfg_t == '0) ? TW'(1) : ((cfg_t > TW'(TMAX)) ? TW'(TMAX) : cfg_t);
    assign two_t    = IW'(t_q) << 1;
    assign last_bit = (bitn == (wide_q ? BW'(MW - 1) : BW'(MW - 2)));
    assign last_idx = (idx == two_t);
    assign ps_rsel  = KW'(idx >> 1);
    assign acc_nxt  = ps_word[bitn] ? (acc_q ^ run_q) : acc_q;

    always_comb begin
        mul_a = run_q;
        mul_b = step_q;
        if (state == ST_EVEN) begin
            mul_a = half_val;
            mul_b = half_val;
        end else if (last_bit) begin
            mul_a = step_q;
            mul_b = GF_ALPHA2;
        end
    end

    always_comb begin
        syn_we    = 1'b0;
        syn_wdata = acc_nxt;
        if (state == ST_ODD && last_bit) begin
            syn_we = 1'b1;
        end else if (state == ST_EVEN) begin
            syn_we    = 1'b1;
            syn_wdata = mul_y;
        end
    end

    bch_gf_mul u_mul (
        .op_a (mul_a),
        .op_b (mul_b),
        .wide (wide_q),
        .prod (mul_y)
    );

    bch_ps_file u_ps (
        .clk   (clk),
        .rst   (rst),
        .we    (ps_we),
        .waddr (ps_addr),
        .wdata (ps_data),
        .raddr (ps_rsel),
        .rdata (ps_word)
    );

    bch_syn_file u_syn (
        .clk     (clk),
        .rst     (rst),
        .clr     (go),
        .we      (syn_we),
        .waddr   (idx),
        .wdata   (syn_wdata),
        .raddr_a (rd_addr),
        .rdata_a (rd_data),
        .raddr_b (IW'(idx >> 1)),
        .rdata_b (half_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            bitn   <= '0;
            t_q    <= TW'(1);
            wide_q <= 1'b0;
            step_q <= GF_ALPHA;
            run_q  <= GF_ONE;
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_ODD;
                        idx    <= IW'(1);
                        bitn   <= '0;
                        t_q    <= t_in;
                        wide_q <= cfg_wide;
                        step_q <= GF_ALPHA;
                        run_q  <= GF_ONE;
                        acc_q  <= '0;
                    end
                end
                ST_ODD: begin
                    if (last_bit) begin
                        state  <= ST_EVEN;
                        idx    <= idx + IW'(1);
                        bitn   <= '0;
                        step_q <= mul_y;
                        run_q  <= GF_ONE;
                        acc_q  <= '0;
                    end else begin
                        bitn  <= bitn + BW'(1);
                        run_q <= mul_y;
                        acc_q <= acc_nxt;
                    end
                end
                ST_EVEN: begin
                    if (last_idx) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_ODD;
                        idx   <= idx + IW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(state == ST_EVEN && idx == two_t)); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(t_q) && $stable(wide_q))); // R7
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (idx >= IW'(1) && idx <= two_t)); // R10
    AST_SQUARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EVEN && half_val == '0) |-> (mul_y == '0)); // R4
endmodule

// File: tb/sim_bch_syn_expand.sv
`timescale 1ns/1ps
module sim_bch_syn_expand;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  cfg_t = 5'd2;
    logic        cfg_wide = 1'b0;
    logic        ps_we = 1'b0;
    logic [4:0]  ps_addr = '0;
    logic [13:0] ps_data = '0;
    logic        done;
    logic [5:0]  rd_addr = '0;
    logic [13:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bch_syn_expand u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_t(cfg_t), .cfg_wide(cfg_wide),
        .ps_we(ps_we), .ps_addr(ps_addr), .ps_data(ps_data), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // ---------------- behavioural reference ----------------
    int ps_sh [0:23];
    int exp_syn [0:49];
    bit m_busy, m_done;
    int m_left;

    function automatic int f_deg(bit w);
        return w ? 14 : 13;
    endfunction

    function automatic int f_times_x(int v, bit w);
        int r;
        r = v << 1;
        if ((r >> f_deg(w)) & 1) r = r ^ (w ? 'h4443 : 'h201B);
        return r;
    endfunction

    function automatic int f_pow(int e, bit w);
        int p;
        p = 1;
        for (int q = 0; q < e; q++) p = f_times_x(p, w);
        return p;
    endfunction

    function automatic int f_log(int s, bit w);
        int p;
        int n;
        n = (1 << f_deg(w)) - 1;
        p = 1;
        for (int e = 0; e < n; e++) begin
            if (p == s) return e;
            p = f_times_x(p, w);
        end
        return 0;
    endfunction

    task automatic build_expect(int t, bit w);
        int n;
        int mdeg;
        int word;
        int s;
        mdeg = f_deg(w);
        n = (1 << mdeg) - 1;
        for (int a = 0; a < 50; a++) exp_syn[a] = 0;
        for (int i = 1; i <= 2 * t; i++) begin
            if (i % 2 == 1) begin
                word = ps_sh[i / 2] & n;
                s = 0;
                for (int j = 0; j < mdeg; j++)
                    if ((word >> j) & 1) s = s ^ f_pow((i * j) % n, w);
                exp_syn[i] = s;
            end else begin
                s = exp_syn[i / 2];
                exp_syn[i] = (s == 0) ? 0 : f_pow((2 * f_log(s, w)) % n, w);
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst && ps_we && ps_addr < 24) ps_sh[ps_addr] = int'(ps_data);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_left <= 0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && start) begin
                m_busy <= 1'b1;
                m_left <= int'(cfg_t) * (f_deg(cfg_wide) + 1);
                build_expect(int'(cfg_t), cfg_wide);
            end else if (m_busy) begin
                if (m_left == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                end
                m_left <= m_left - 1;
            end
        end
    end

    // every-cycle comparison of the completion pulse
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (done !== m_done) begin
                failures++;
                $display("FAIL R6 done at %0t: got %b exp %b", $time, done, m_done);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string req, string what, int got, int expv);
        checks++;
        if (got != expv) begin
            failures++;
            $display("FAIL %s %s: got %h exp %h", req, what, got, expv);
        end
    endtask

    task automatic put_ps(int k, int d);
        @(negedge clk);
        ps_we = 1'b1; ps_addr = 5'(k); ps_data = 14'(d);
        @(negedge clk);
        ps_we = 1'b0;
    endtask

    task automatic fill_ps(int seed);
        int v;
        v = seed;
        for (int k = 0; k < 24; k++) begin
            v = v ^ (v << 13); v = v ^ (v >> 17); v = v ^ (v << 5);
            put_ps(k, (k % 7 == 3) ? 0 : (v & 'h3FFF));
        end
    endtask

    task automatic launch(int t, bit w, bit poke);
        int guard;
        @(negedge clk);
        start = 1'b1; cfg_t = 5'(t); cfg_wide = w;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; cfg_t = 5'd24; cfg_wide = ~w;   // R7: must be ignored
            @(negedge clk);
            start = 1'b0; cfg_t = 5'd1;
        end
        guard = 0;
        while (done !== 1'b1 && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic read_all(int t, string tag);
        string req;
        for (int a = 0; a < 50; a++) begin
            rd_addr = 6'(a);
            #0.5;
            if (a == 0) req = "R8";
            else if (a > 2 * t) req = "R5";
            else if (a % 2 == 1) req = "R3";
            else req = "R4";
            chk(req, $sformatf("%s slot %0d", tag, a), int'(rd_data), exp_syn[a]);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 50; a += 7) begin
            rd_addr = 6'(a);
            #0.5;
            chk("R1", $sformatf("slot %0d after reset", a), int'(rd_data), 0);
        end

        // R2 literal field checks, t=1
        put_ps(0, 'h1000);
        launch(1, 1'b0, 1'b0);
        rd_addr = 6'd1; #0.5; chk("R2", "narrow S1", int'(rd_data), 'h1000);
        rd_addr = 6'd2; #0.5; chk("R2", "narrow S2", int'(rd_data), 'h185A);
        put_ps(0, 'h2000);
        launch(1, 1'b1, 1'b0);
        rd_addr = 6'd1; #0.5; chk("R2", "wide S1", int'(rd_data), 'h2000);
        rd_addr = 6'd2; #0.5; chk("R2", "wide S2", int'(rd_data), 'h3743);
        read_all(1, "R10 t1 wide");

        fill_ps(32'h1234_5678);
        launch(2, 1'b0, 1'b0);  read_all(2, "t2 narrow");
        launch(4, 1'b1, 1'b0);  read_all(4, "t4 wide");
        launch(24, 1'b0, 1'b0); read_all(24, "R9 R10 t24 narrow");
        launch(8, 1'b0, 1'b0);  read_all(8, "R5 t8 after t24");
        fill_ps(32'h0BAD_F00D);
        launch(24, 1'b1, 1'b0); read_all(24, "R10 t24 wide");
        launch(12, 1'b1, 1'b1); read_all(12, "R7 t12 wide poked");
        launch(2, 1'b1, 1'b0);  read_all(2, "R5 t2 after t12");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule